// File: doc/BRIEF.md
# Cascaded Module Level Allocator

This block sits in the modulator of a rectifier built from three cascaded three-level modules. Each module's bridge can place one of five levels on its input: −2, −1, 0, +1 or +2 units of the capacitor voltage E. Every time the modulator's reference crosses into a new band, it raises a one-cycle trigger. On that trigger the block moves the total input level up or down by one unit, and it does so by stepping exactly one module. The module is chosen from a ranking of the DC-link voltages, so that over time the modules are pushed back toward equal voltages. A module that is already at its limit is passed over in favour of the next candidate.

Within the chosen set of levels, the ±1 levels can each be made by two different leg pairs. One pair charges or drains the upper capacitor and the other acts on the lower capacitor. For each module the block picks the pair that pulls its two capacitors together, using the sign of the grid current. The block keeps the two vectors that bound the present band. Vector A holds the levels before the last trigger and vector B the levels after it, together with the leg pairs that realise vector B.

Top module: `cascade_level_allocator`

## Requirements
- R1: Each module level is a 3-bit two's complement value, module m in bits [3m+2:3m] of `vec_a_o` and `vec_b_o`, and always lies in −2..+2.
- R2: After reset both level vectors are all zero and all leg outputs are zero.
- R3: With positive current (`cur_pos_i`=1) and a rise (`rise_i`=1), the module with the lowest DC-link voltage gains one level. If it is at +2 the middle module gains instead, and if that is also at +2 the highest one gains.
- R4: With positive current and a fall (`rise_i`=0), the module with the highest voltage loses one level. If it is at −2 the middle module loses instead, then the lowest.
- R5: With negative current the search order is mirrored: a rise starts at the highest-voltage module and a fall starts at the lowest, each falling back through the middle module to the remaining one.
- R6: Equal DC-link voltages are ranked by module index: the lower index counts as the higher voltage.
- R7: A trigger changes exactly one module by exactly one level. When every module is already at the limit in the requested direction, nothing changes.
- R8: On a trigger, the old vector B appears on `vec_a_o` and the new levels appear on `vec_b_o`, both one clock after the trigger cycle. Without a trigger, all outputs hold their values whatever the other inputs do.
- R9: Leg values are 2-bit two's complement (+1=01, 0=00, −1=11). Module m uses bits [2m+1:2m] of `leg_a_o` and `leg_b_o`, and leg_a minus leg_b equals the module's vector B level. The fixed pairs are: +2 as (+1,−1), 0 as (0,0), −2 as (−1,+1).
- R10: For a ±1 level, call a module's capacitors "alike" with the current when (VC1 ≥ VC2 and current positive) or (VC1 < VC2 and current negative). Equal capacitor voltages count as VC1 > VC2. If alike, +1 uses (0,−1) and −1 uses (−1,0); otherwise +1 uses (+1,0) and −1 uses (0,+1). The capacitor voltages and current sign are those present in the trigger cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | One allocation per cycle in which it is high |
| rise_i | input | 1 | 1 = raise total level, 0 = lower it |
| cur_pos_i | input | 1 | 1 = grid current positive |
| vdc_i | input | 3*VW | DC-link voltage per module, unsigned, module m at [VW*m +: VW] |
| vc1_i | input | 3*VW | Upper capacitor voltage per module |
| vc2_i | input | 3*VW | Lower capacitor voltage per module |
| vec_a_o | output | 9 | Levels before the last trigger |
| vec_b_o | output | 9 | Levels after the last trigger |
| leg_a_o | output | 6 | First bridge leg state per module for vector B |
| leg_b_o | output | 6 | Second bridge leg state per module for vector B |

## Verification
The only state is the two level vectors and the leg pairs, and all of it is visible at the ports. A wrong ranking or fallback shows up as the wrong module moving, or a saturated module moving, on `vec_b_o` one clock after the trigger. A broken copy path shows on `vec_a_o` at that same clock. Since vector A must always match vector B in all but one module, by at most one level, a stray step is seen as soon as it happens and does not need to build up over many triggers. Errors in leg selection show up on the leg outputs in the same cycle as the level they realise.

// File: rtl/lvl_alloc_pkg.sv
package lvl_alloc_pkg;
  localparam int unsigned NMOD = 3;
  localparam int unsigned LW   = 3;
  localparam int unsigned GW   = 2;
  localparam int unsigned RW   = $clog2(NMOD);

  typedef logic signed [LW-1:0] level_t;
  typedef logic signed [GW-1:0] leg_t;

  localparam level_t LVL_TOP = 3'sd2;
  localparam level_t LVL_BOT = -3'sd2;

  localparam leg_t LEG_P = 2'sb01;
  localparam leg_t LEG_Z = 2'sb00;
  localparam leg_t LEG_N = 2'sb11;
endpackage

// File: rtl/lvl_rank.sv
// rank 0 = highest voltage; ties go to the lower index
module lvl_rank
  import lvl_alloc_pkg::*;
#(
  parameter int unsigned VW = 12
) (
  input  logic [NMOD*VW-1:0] vdc_i,
  output logic [NMOD*RW-1:0] rank_o
);
  always_comb begin
    rank_o = '0;
    for (int i = 0; i < NMOD; i++) begin
      int unsigned beaten;
      beaten = 0;
      for (int j = 0; j < NMOD; j++) begin
        if (j != i) begin
          if ((vdc_i[j*VW +: VW] > vdc_i[i*VW +: VW]) ||
              ((vdc_i[j*VW +: VW] == vdc_i[i*VW +: VW]) && (j < i)))
            beaten++;
        end
      end
      rank_o[i*RW +: RW] = RW'(beaten);
    end
  end
endmodule

// File: rtl/lvl_pick.sv
module lvl_pick
  import lvl_alloc_pkg::*;
(
  input  logic [NMOD*RW-1:0] rank_i,
  input  logic [NMOD*LW-1:0] lvl_i,
  input  logic               rise_i,
  input  logic               cur_pos_i,
  output logic [NMOD*LW-1:0] lvl_o
);
  logic            from_low;
  level_t          limit;
  level_t          step;
  logic [NMOD-1:0] sel;

  // rising with positive current or falling with negative current starts at the lowest rank
  assign from_low = (rise_i == cur_pos_i);
  assign limit    = rise_i ? LVL_TOP : LVL_BOT;
  assign step     = rise_i ? 3'sd1 : -3'sd1;

  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int p = 0; p < NMOD; p++) begin
      logic [RW-1:0] tgt;
      tgt = from_low ? RW'(NMOD-1-p) : RW'(p);
      for (int m = 0; m < NMOD; m++) begin
        if (!found && (rank_i[m*RW +: RW] == tgt) &&
            (level_t'(lvl_i[m*LW +: LW]) != limit)) begin
          sel[m] = 1'b1;
          found  = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int m = 0; m < NMOD; m++) begin
      level_t cur;
      cur = level_t'(lvl_i[m*LW +: LW]);
      lvl_o[m*LW +: LW] = sel[m] ? (cur + step) : cur;
    end
  end
endmodule

// File: rtl/lvl_leg_map.sv
module lvl_leg_map
  import lvl_alloc_pkg::*;
#(
  parameter int unsigned VW = 12
) (
  input  logic [LW-1:0] lvl_i,
  input  logic [VW-1:0] vc1_i,
  input  logic [VW-1:0] vc2_i,
  input  logic          cur_pos_i,
  output logic [GW-1:0] leg_a_o,
  output logic [GW-1:0] leg_b_o
);
  logic alike;
  assign alike = ((vc1_i >= vc2_i) == cur_pos_i);

  always_comb begin
    unique case (lvl_i)
      3'b010: begin leg_a_o = LEG_P; leg_b_o = LEG_N; end
      3'b001: begin
        if (alike) begin leg_a_o = LEG_Z; leg_b_o = LEG_N; end
        else       begin leg_a_o = LEG_P; leg_b_o = LEG_Z; end
      end
      3'b111: begin
        if (alike) begin leg_a_o = LEG_N; leg_b_o = LEG_Z; end
        else       begin leg_a_o = LEG_Z; leg_b_o = LEG_P; end
      end
      3'b110: begin leg_a_o = LEG_N; leg_b_o = LEG_P; end
      default: begin leg_a_o = LEG_Z; leg_b_o = LEG_Z; end
    endcase
  end
endmodule

// File: rtl/cascade_level_allocator.sv
module cascade_level_allocator
  import lvl_alloc_pkg::*;
#(
  parameter int unsigned VW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic               rise_i,
  input  logic               cur_pos_i,
  input  logic [NMOD*VW-1:0] vdc_i,
  input  logic [NMOD*VW-1:0] vc1_i,
  input  logic [NMOD*VW-1:0] vc2_i,
  output logic [NMOD*LW-1:0] vec_a_o,
  output logic [NMOD*LW-1:0] vec_b_o,
  output logic [NMOD*GW-1:0] leg_a_o,
  output logic [NMOD*GW-1:0] leg_b_o
);
  logic [NMOD*RW-1:0] rank;
  logic [NMOD*LW-1:0] lvl_nxt;
  logic [NMOD*GW-1:0] leg_a_nxt, leg_b_nxt;
  logic [NMOD*LW-1:0] vec_a_q, vec_b_q;
  logic [NMOD*GW-1:0] leg_a_q, leg_b_q;

  lvl_rank #(.VW(VW)) u_rank (
    .vdc_i  (vdc_i),
    .rank_o (rank)
  );

  lvl_pick u_pick (
    .rank_i    (rank),
    .lvl_i     (vec_b_q),
    .rise_i    (rise_i),
    .cur_pos_i (cur_pos_i),
    .lvl_o     (lvl_nxt)
  );

  for (genvar m = 0; m < NMOD; m++) begin : g_leg
    lvl_leg_map #(.VW(VW)) u_map (
      .lvl_i     (lvl_nxt[m*LW +: LW]),
      .vc1_i     (vc1_i[m*VW +: VW]),
      .vc2_i     (vc2_i[m*VW +: VW]),
      .cur_pos_i (cur_pos_i),
      .leg_a_o   (leg_a_nxt[m*GW +: GW]),
      .leg_b_o   (leg_b_nxt[m*GW +: GW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_a_q <= '0;
      vec_b_q <= '0;
      leg_a_q <= '0;
      leg_b_q <= '0;
    end else if (trig_i) begin
      vec_a_q <= vec_b_q;
      vec_b_q <= lvl_nxt;
      leg_a_q <= leg_a_nxt;
      leg_b_q <= leg_b_nxt;
    end
  end

  assign vec_a_o = vec_a_q;
  assign vec_b_o = vec_b_q;
  assign leg_a_o = leg_a_q;
  assign leg_b_o = leg_b_q;
endmodule

// File: rtl/lvl_alloc_chk.sv
module lvl_alloc_chk
  import lvl_alloc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               trig_i,
  input logic [NMOD*LW-1:0] vec_a_o,
  input logic [NMOD*LW-1:0] vec_b_o,
  input logic [NMOD*GW-1:0] leg_a_o,
  input logic [NMOD*GW-1:0] leg_b_o
);
  logic [NMOD-1:0] differs;
  logic [NMOD-1:0] small_step;

  for (genvar m = 0; m < NMOD; m++) begin : g_mod
    level_t lb, la;
    logic signed [LW:0] dlt;
    logic signed [LW-1:0] ga3, gb3;
    assign lb  = level_t'(vec_b_o[m*LW +: LW]);
    assign la  = level_t'(vec_a_o[m*LW +: LW]);
    assign dlt = {lb[LW-1], lb} - {la[LW-1], la};
    assign differs[m]    = (la != lb);
    assign small_step[m] = (dlt >= -4'sd1) && (dlt <= 4'sd1);
    assign ga3 = {leg_a_o[m*GW+1], leg_a_o[m*GW +: GW]};
    assign gb3 = {leg_b_o[m*GW+1], leg_b_o[m*GW +: GW]};

    a_r1_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lb >= LVL_BOT) && (lb <= LVL_TOP));

    a_r9_leg_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ga3 - gb3) == lb);
  end

  a_r7_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(differs) && (&small_step));

  a_r8_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (vec_a_o == $past(vec_b_o)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> ($stable(vec_a_o) && $stable(vec_b_o) &&
                 $stable(leg_a_o) && $stable(leg_b_o)));
endmodule

bind cascade_level_allocator lvl_alloc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_i  (trig_i),
  .vec_a_o (vec_a_o),
  .vec_b_o (vec_b_o),
  .leg_a_o (leg_a_o),
  .leg_b_o (leg_b_o)
);

// File: tb/tb_cascade_level_allocator.sv
module tb_cascade_level_allocator;
  localparam int VW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, rise = 1'b0, cpos = 1'b1;
  logic [3*VW-1:0] vdc = '0, vc1 = '0, vc2 = '0;
  logic [8:0] vec_a, vec_b;
  logic [5:0] leg_a, leg_b;

  int n_chk = 0, n_fail = 0;
  int mb[3], ma[3], ga[3], gb[3];
  int vd[3], c1[3], c2[3];

  always #10 clk = ~clk;

  cascade_level_allocator #(.VW(VW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .rise_i(rise), .cur_pos_i(cpos),
    .vdc_i(vdc), .vc1_i(vc1), .vc2_i(vc2),
    .vec_a_o(vec_a), .vec_b_o(vec_b), .leg_a_o(leg_a), .leg_b_o(leg_b)
  );

  function automatic logic [8:0] pk3(int x0, int x1, int x2);
    return {x2[2:0], x1[2:0], x0[2:0]};
  endfunction

  function automatic logic [5:0] pk2(int x0, int x1, int x2);
    return {x2[1:0], x1[1:0], x0[1:0]};
  endfunction

  function automatic int leg_first(int lvl, bit alike);
    case (lvl)
      2:  return 1;
      1:  return alike ? 0 : 1;
      -1: return alike ? -1 : 0;
      -2: return -1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " R8 vec_a"}, vec_a, pk3(ma[0], ma[1], ma[2]));
    chk({tag, " R1 vec_b"}, vec_b, pk3(mb[0], mb[1], mb[2]));
    chk({tag, " R9 leg_a"}, {3'b0, leg_a}, {3'b0, pk2(ga[0], ga[1], ga[2])});
    chk({tag, " R10 leg_b"}, {3'b0, leg_b}, {3'b0, pk2(gb[0], gb[1], gb[2])});
  endtask

  task automatic set_v(int a0, int a1, int a2);
    vd[0] = a0; vd[1] = a1; vd[2] = a2;
  endtask

  task automatic set_c(int m, int u, int l);
    c1[m] = u; c2[m] = l;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trig = 1'b0;
    for (int m = 0; m < 3; m++) begin mb[m] = 0; ma[m] = 0; ga[m] = 0; gb[m] = 0; end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // reference step from the requirements, then drive one trigger
  task automatic step(string tag, bit up, bit pos);
    int rk[3];
    int nb[3];
    bit done;
    int lim;
    for (int i = 0; i < 3; i++) begin
      rk[i] = 0;
      for (int j = 0; j < 3; j++)
        if (j != i && (vd[j] > vd[i] || (vd[j] == vd[i] && j < i))) rk[i]++;
    end
    lim = up ? 2 : -2;
    done = 1'b0;
    nb = mb;
    for (int p = 0; p < 3; p++) begin
      int t;
      t = (up == pos) ? 2 - p : p;
      for (int m = 0; m < 3; m++)
        if (!done && rk[m] == t && mb[m] != lim) begin
          nb[m] = mb[m] + (up ? 1 : -1);
          done = 1'b1;
        end
    end
    ma = mb;
    mb = nb;
    for (int m = 0; m < 3; m++) begin
      ga[m] = leg_first(mb[m], ((c1[m] >= c2[m]) == pos));
      gb[m] = ga[m] - mb[m];
    end
    @(negedge clk);
    vdc  = {vd[2][VW-1:0], vd[1][VW-1:0], vd[0][VW-1:0]};
    vc1  = {c1[2][VW-1:0], c1[1][VW-1:0], c1[0][VW-1:0]};
    vc2  = {c2[2][VW-1:0], c2[1][VW-1:0], c2[0][VW-1:0]};
    rise = up; cpos = pos; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk_all(tag);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 vec_a", vec_a, '0);
    chk("R2 vec_b", vec_b, '0);
    chk("R2 legs", {3'b0, leg_a | leg_b}, '0);
  endtask

  task automatic t_rise_pos();
    do_reset();
    set_v(10, 20, 30);
    for (int m = 0; m < 3; m++) set_c(m, 50, 50);
    step("R3 first", 1, 1);
    chk("R3 lowest gains", vec_b, pk3(1, 0, 0));
    for (int k = 0; k < 6; k++) step("R3 fallback", 1, 1);
    chk("R3 R7 all top", vec_b, pk3(2, 2, 2));
    step("R7 saturated rise", 1, 1);
    chk("R7 no change", vec_b, pk3(2, 2, 2));
  endtask

  task automatic t_fall_pos();
    set_v(40, 70, 55);
    for (int k = 0; k < 12; k++) step("R4 fall", 0, 1);
    chk("R4 all bottom", vec_b, pk3(-2, -2, -2));
    step("R7 saturated fall", 0, 1);
  endtask

  task automatic t_neg();
    do_reset();
    set_v(10, 20, 30);
    step("R5 rise", 1, 0);
    chk("R5 highest gains", vec_b, pk3(0, 0, 1));
    step("R5 fall", 0, 0);
    chk("R5 lowest loses", vec_b, pk3(-1, 0, 1));
    for (int k = 0; k < 8; k++) step("R5 fall seq", 0, 0);
    for (int k = 0; k < 6; k++) step("R5 rise seq", 1, 0);
  endtask

  task automatic t_ties();
    do_reset();
    set_v(5, 5, 5);
    step("R6 rise tie", 1, 1);
    chk("R6 last index lowest", vec_b, pk3(0, 0, 1));
    step("R6 fall tie", 0, 1);
    chk("R6 first index highest", vec_b, pk3(-1, 0, 1));
    set_v(9, 9, 3);
    step("R6 partial tie", 0, 1);
  endtask

  task automatic t_legs();
    do_reset();
    set_c(0, 80, 60);
    set_c(1, 60, 80);
    set_c(2, 70, 70);
    set_v(10, 20, 30);
    step("R10 pos", 1, 1);
    set_v(30, 10, 20);
    step("R10 pos", 1, 1);
    set_v(20, 30, 10);
    step("R10 pos", 1, 1);
    step("R10 neg", 1, 0);
    set_v(10, 20, 30);
    for (int k = 0; k < 5; k++) step("R10 neg fall", 0, 0);
    for (int k = 0; k < 4; k++) step("R10 pos fall", 0, 1);
    for (int k = 0; k < 3; k++) step("R9 rise", 1, 0);
  endtask

  task automatic t_hold();
    do_reset();
    set_v(10, 20, 30);
    for (int m = 0; m < 3; m++) set_c(m, 10, 20);
    step("R8 seed", 1, 1);
    step("R8 seed", 1, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      vdc = {12'd1, 12'd900, 12'd5};
      vc1 = ~vc1;
      rise = ~rise; cpos = ~cpos;
      @(negedge clk);
      chk_all("R8 hold");
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int m = 0; m < 3; m++) begin vd[m] = 0; c1[m] = 0; c2[m] = 0; end
    repeat (2) @(negedge clk);
    t_reset();
    t_rise_pos();
    t_fall_pos();
    t_neg();
    t_ties();
    t_legs();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule